// File: doc/BRIEF.md
# Transceiver Line-Rate Reconfiguration Sequencer

This block retunes a serial transceiver to a new line rate. It receives a rate code and a start pulse. It then reprograms the shared quad PLL and one transceiver channel through two separate register ports. After the last write it resets the PLL and waits for the PLL to report lock. It finishes with a one-cycle restart pulse on both the transmit and receive datapaths.

The rate code gives the nominal line rate in Gb/s, rounded down. The valid codes are 1, 2, 3, 5, 6, 10 and 12, for 1.25, 2.5, 3.125, 5, 6.25, 10 and 12.5 Gb/s. The block looks up every register value combinationally from the code it latched when the start was accepted.

The block does not trust its partners to answer. A programmable cycle limit bounds every wait for ready and the wait for lock. When a limit runs out, the block sets a sticky error flag and stops.

While a rate change is running, the block holds the upstream link's clock in reset. It also keeps a double-bitrate select for that link up to date.

The states are:
- ST_IDLE
- ST_LOOKUP, which validates the code
- ST_ISSUE, which issues the write strobe
- ST_AWAIT, which waits for ready
- ST_PLLRST
- ST_LOCKWAIT
- ST_KICK, which issues the restart pulses
- ST_FINISH, which issues the done pulse
- ST_FAULT

The transitions are:
- IDLE goes to LOOKUP on start.
- LOOKUP goes to ISSUE for a valid code, or to FAULT for an invalid one.
- ISSUE goes to AWAIT.
- AWAIT goes back to ISSUE on ready if writes remain. On ready after the seventh write it goes to PLLRST. On timeout it goes to FAULT.
- PLLRST goes to LOCKWAIT.
- LOCKWAIT goes to KICK on lock, or to FAULT on timeout.
- KICK goes to FINISH.
- FINISH goes to IDLE.
- FAULT goes to IDLE.

Top module: `xcvr_rate_seq`

## Requirements
- R1: A start is accepted only in idle. From the next cycle, `busy` stays high up to and including the cycle of the restart pulses. `done` is high for exactly the following cycle, with `busy` low.
- R2: The first write goes to PLL address 0x36. It carries 0x0170 for codes 3, 6 and 12, and 0x0120 for codes 1, 2, 5 and 10.
- R3: The second write goes to channel address 0x88. It carries 0x33 for code 1, 0x22 for codes 2 and 3, 0x11 for codes 5 and 6, and 0x00 for codes 10 and 12.
- R4: Five channel writes follow, to addresses 0xA8, 0xA9, 0xAA, 0xAB and 0xAC in that order. They carry 0x0020, then the recovery word, then 0x23FF, then 0x0000, then the tail word. The recovery word is 0x1008, 0x1010, 0x1020 or 0x1040 for a channel divide of 8, 4, 2 or 1. The tail word is 0x000B for codes 10 and 12, and 0x0003 otherwise.
- R5: Every write is a one-cycle strobe on exactly one port. The next strobe comes only after that port has returned `ready`. Both read strobes stay low.
- R6: One cycle after the last ready, `pll_reset` pulses for one cycle. The block then waits for `pll_locked`. One cycle after it sees lock, it pulses `tx_restart` and `rx_restart` together.
- R7: A wait that lasts `timeout_cycles`+1 cycles without ready or lock ends the run. The error flag is set, and there is no restart and no done. If ready arrives in the last permitted cycle, ready takes precedence.
- R8: `error` is sticky until the next accepted start, and it reads low from the cycle after that start.
- R9: A rate code outside the seven valid values sets `error` and causes no write and no restart.
- R10: `up_clk_reset` equals `busy`. `up_double_rate` becomes 1 for codes 10 and 12 and 0 for the other valid codes, and holds that value after the run.
- R11: A start that arrives while a run is in progress is ignored. The running program continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a rate change |
| rate_code | input | 4 | Target rate code |
| timeout_cycles | input | 16 | Wait limit for ready and lock |
| pll_addr | output | 8 | PLL register address |
| pll_wdata | output | 16 | PLL write data |
| pll_wr | output | 1 | PLL write strobe |
| pll_rd | output | 1 | PLL read strobe (held low) |
| pll_ready | input | 1 | PLL access complete |
| pll_rdata | input | 16 | PLL read data (unused) |
| ch_addr | output | 8 | Channel register address |
| ch_wdata | output | 16 | Channel write data |
| ch_wr | output | 1 | Channel write strobe |
| ch_rd | output | 1 | Channel read strobe (held low) |
| ch_ready | input | 1 | Channel access complete |
| ch_rdata | input | 16 | Channel read data (unused) |
| pll_reset | output | 1 | PLL reset pulse |
| pll_locked | input | 1 | PLL lock indication |
| tx_restart | output | 1 | Transmit datapath restart pulse |
| rx_restart | output | 1 | Receive datapath restart pulse |
| up_clk_reset | output | 1 | Upstream link clock reset |
| up_double_rate | output | 1 | Upstream link double-bitrate select |
| busy | output | 1 | Rate change in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Sticky failure flag |

## Verification
The critical collision is a ready or lock edge that arrives in the same cycle the wait limit expires. The bench provokes it by setting the responder latency to exactly `timeout_cycles`+1, which must complete the run, and then to one cycle more, which must end in error.

A second collision is a new start that lands while a sequence is running. The bench checks that the write stream still matches the first code and that the double-rate select still reflects that code.

The behavioural model in the bench predicts every write from the rate code and compares each strobe against that prediction in the cycle it occurs.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ISSUE,
        ST_AWAIT,
        ST_PLLRST,
        ST_LOCKWAIT,
        ST_KICK,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

    localparam int NUM_STEPS = 7;
    localparam logic [7:0] PLL_FB_ADDR  = 8'h36;
    localparam logic [7:0] CH_DIV_ADDR  = 8'h88;
    localparam logic [7:0] CDR_BASE     = 8'hA8;

endpackage

// File: rtl/xrs_rate_rom.sv
module xrs_rate_rom #(
    parameter int DW = 16
) (
    input  logic [3:0]    code,
    output logic          valid,
    output logic          hi_rate,
    output logic [DW-1:0] fb_word,
    output logic [DW-1:0] div_word,
    output logic [DW-1:0] cdr_mid,
    output logic [DW-1:0] cdr_tail
);
    logic [1:0] div_log;   // log2 of channel divide
    logic       fb100;

    always_comb begin
        valid   = 1'b1;
        fb100   = 1'b0;
        div_log = 2'd0;
        case (code)
            4'd1:    div_log = 2'd3;
            4'd2:    div_log = 2'd2;
            4'd3:    begin div_log = 2'd2; fb100 = 1'b1; end
            4'd5:    div_log = 2'd1;
            4'd6:    begin div_log = 2'd1; fb100 = 1'b1; end
            4'd10:   div_log = 2'd0;
            4'd12:   begin div_log = 2'd0; fb100 = 1'b1; end
            default: valid = 1'b0;
        endcase
    end

    assign hi_rate  = valid && (div_log == 2'd0);
    assign fb_word  = fb100 ? DW'(16'h0170) : DW'(16'h0120);
    assign div_word = DW'({2'b00, div_log, 2'b00, div_log});
    assign cdr_mid  = DW'(16'h1000 | (16'h0040 >> div_log));
    assign cdr_tail = hi_rate ? DW'(16'h000B) : DW'(16'h0003);
endmodule

// File: rtl/xrs_step_mux.sv
module xrs_step_mux
    import xrs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [2:0]    step,
    input  logic [DW-1:0] fb_word,
    input  logic [DW-1:0] div_word,
    input  logic [DW-1:0] cdr_mid,
    input  logic [DW-1:0] cdr_tail,
    output logic          to_pll,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    always_comb begin
        to_pll = (step == 3'd0);
        addr   = AW'(CDR_BASE + 8'(step) - 8'd2);
        data   = '0;
        case (step)
            3'd0: begin addr = AW'(PLL_FB_ADDR); data = fb_word; end
            3'd1: begin addr = AW'(CH_DIV_ADDR); data = div_word; end
            3'd2: data = DW'(16'h0020);
            3'd3: data = cdr_mid;
            3'd4: data = DW'(16'h23FF);
            3'd5: data = '0;
            default: data = cdr_tail;
        endcase
    end
endmodule

// File: rtl/xrs_wait_timer.sv
module xrs_wait_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt >= limit);
endmodule

// File: rtl/xcvr_rate_seq.sv
module xcvr_rate_seq
    import xrs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    rate_code,
    input  logic [TW-1:0] timeout_cycles,
    output logic [AW-1:0] pll_addr,
    output logic [DW-1:0] pll_wdata,
    output logic          pll_wr,
    output logic          pll_rd,
    input  logic          pll_ready,
    input  logic [DW-1:0] pll_rdata,
    output logic [AW-1:0] ch_addr,
    output logic [DW-1:0] ch_wdata,
    output logic          ch_wr,
    output logic          ch_rd,
    input  logic          ch_ready,
    input  logic [DW-1:0] ch_rdata,
    output logic          pll_reset,
    input  logic          pll_locked,
    output logic          tx_restart,
    output logic          rx_restart,
    output logic          up_clk_reset,
    output logic          up_double_rate,
    output logic          busy,
    output logic          done,
    output logic          error
);
    localparam logic [2:0] LAST_STEP = 3'(NUM_STEPS - 1);

    seq_state_t    state, nxt;
    logic [3:0]    code_q;
    logic [2:0]    step;
    logic          tbl_valid, tbl_hi;
    logic [DW-1:0] fb_word, div_word, cdr_mid, cdr_tail;
    logic          to_pll;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] acc_data;
    logic          port_ready, expired, in_wait;
    logic          unused_rdata;

    assign unused_rdata = ^{pll_rdata, ch_rdata};

    xrs_rate_rom #(.DW(DW)) u_rom (
        .code(code_q), .valid(tbl_valid), .hi_rate(tbl_hi),
        .fb_word(fb_word), .div_word(div_word),
        .cdr_mid(cdr_mid), .cdr_tail(cdr_tail)
    );

    xrs_step_mux #(.AW(AW), .DW(DW)) u_mux (
        .step(step), .fb_word(fb_word), .div_word(div_word),
        .cdr_mid(cdr_mid), .cdr_tail(cdr_tail),
        .to_pll(to_pll), .addr(acc_addr), .data(acc_data)
    );

    assign in_wait = (state == ST_AWAIT) || (state == ST_LOCKWAIT);

    xrs_wait_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clear(!in_wait),
        .limit(timeout_cycles), .expired(expired)
    );

    assign port_ready = to_pll ? pll_ready : ch_ready;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start) nxt = ST_LOOKUP;
            ST_LOOKUP:   nxt = tbl_valid ? ST_ISSUE : ST_FAULT;
            ST_ISSUE:    nxt = ST_AWAIT;
            ST_AWAIT:
                if (port_ready)  nxt = (step == LAST_STEP) ? ST_PLLRST : ST_ISSUE;
                else if (expired) nxt = ST_FAULT;
            ST_PLLRST:   nxt = ST_LOCKWAIT;
            ST_LOCKWAIT:
                if (pll_locked)  nxt = ST_KICK;
                else if (expired) nxt = ST_FAULT;
            ST_KICK:     nxt = ST_FINISH;
            ST_FINISH:   nxt = ST_IDLE;
            ST_FAULT:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register and sequencing state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_IDLE;
            code_q         <= '0;
            step           <= '0;
            error          <= 1'b0;
            up_double_rate <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                code_q <= rate_code;
                step   <= '0;
                error  <= 1'b0;
            end
            if (state == ST_LOOKUP && tbl_valid)
                up_double_rate <= tbl_hi;
            if (state == ST_AWAIT && port_ready && step != LAST_STEP)
                step <= step + 3'd1;
            if (state == ST_FAULT)
                error <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        busy       = !(state == ST_IDLE || state == ST_FINISH);
        pll_wr     = (state == ST_ISSUE) &&  to_pll;
        ch_wr      = (state == ST_ISSUE) && !to_pll;
        pll_reset  = (state == ST_PLLRST);
        tx_restart = (state == ST_KICK);
        rx_restart = (state == ST_KICK);
        done       = (state == ST_FINISH);
        pll_rd     = 1'b0;
        ch_rd      = 1'b0;
        pll_addr   = acc_addr;
        pll_wdata  = acc_data;
        ch_addr    = acc_addr;
        ch_wdata   = acc_data;
    end

    assign up_clk_reset = busy;
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic pll_wr,
    input logic ch_wr,
    input logic pll_reset,
    input logic pll_locked,
    input logic tx_restart,
    input logic busy,
    input logic done,
    input logic error
);
    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_wr && ch_wr)); // R5
    AST_PLL_WR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        pll_wr |=> !pll_wr); // R5
    AST_CH_WR_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wr |=> !ch_wr); // R5
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R1
    AST_DONE_AFTER_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_restart |=> done); // R1
    AST_KICK_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_restart |-> $past(pll_locked)); // R6
    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset |=> !pll_reset); // R6
    AST_ERR_BLOCKS_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !tx_restart); // R7
endmodule

bind xcvr_rate_seq xrs_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_wr(pll_wr), .ch_wr(ch_wr),
    .pll_reset(pll_reset), .pll_locked(pll_locked), .tx_restart(tx_restart),
    .busy(busy), .done(done), .error(error)
);

// File: tb/sim_xcvr_rate_seq.sv
`timescale 1ns/1ps
module sim_xcvr_rate_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  rate_code = '0;
    logic [15:0] timeout_cycles = 16'd20;
    logic [7:0]  pll_addr, ch_addr;
    logic [15:0] pll_wdata, ch_wdata;
    logic        pll_wr, pll_rd, ch_wr, ch_rd;
    logic        pll_ready = 1'b0, ch_ready = 1'b0, pll_locked = 1'b1;
    logic        pll_reset, tx_restart, rx_restart, up_clk_reset, up_double_rate;
    logic        busy, done, error;

    always #2 clk = ~clk;

    xcvr_rate_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_code(rate_code),
        .timeout_cycles(timeout_cycles),
        .pll_addr(pll_addr), .pll_wdata(pll_wdata), .pll_wr(pll_wr), .pll_rd(pll_rd),
        .pll_ready(pll_ready), .pll_rdata(16'h0000),
        .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_wr(ch_wr), .ch_rd(ch_rd),
        .ch_ready(ch_ready), .ch_rdata(16'h0000),
        .pll_reset(pll_reset), .pll_locked(pll_locked),
        .tx_restart(tx_restart), .rx_restart(rx_restart),
        .up_clk_reset(up_clk_reset), .up_double_rate(up_double_rate),
        .busy(busy), .done(done), .error(error)
    );

    int total = 0, bad = 0;
    int exp_port[$], exp_addr[$], exp_data[$];
    int pll_lat = 2, ch_lat = 3, lock_lat = 5;
    bit pll_drop = 0, ch_drop = 0, lock_never = 0;
    int pll_cd = 0, ch_cd = 0, lock_cd = 0;
    int restart_cnt = 0, done_cnt = 0, wr_cnt = 0;
    bit lock_seen = 0;

    function automatic void chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endfunction

    // reference program from the requirements
    function automatic void push_prog(int code, int n);
        int p[7], a[7], d[7];
        int dv, fb, chv, a9, ac;
        fb = (code == 3 || code == 6 || code == 12) ? 'h0170 : 'h0120;
        if (code == 1) dv = 8;
        else if (code == 2 || code == 3) dv = 4;
        else if (code == 5 || code == 6) dv = 2;
        else dv = 1;
        chv = (dv == 8) ? 'h33 : (dv == 4) ? 'h22 : (dv == 2) ? 'h11 : 'h00;
        a9  = (dv == 8) ? 'h1008 : (dv == 4) ? 'h1010 : (dv == 2) ? 'h1020 : 'h1040;
        ac  = (code >= 10) ? 'h000B : 'h0003;
        p = '{1, 0, 0, 0, 0, 0, 0};
        a = '{'h36, 'h88, 'hA8, 'hA9, 'hAA, 'hAB, 'hAC};
        d = '{fb, chv, 'h0020, a9, 'h23FF, 'h0000, ac};
        for (int i = 0; i < n; i++) begin
            exp_port.push_back(p[i]);
            exp_addr.push_back(a[i]);
            exp_data.push_back(d[i]);
        end
    endfunction

    // partner models and per-cycle comparison
    always @(negedge clk) begin
        pll_ready = 1'b0;
        ch_ready  = 1'b0;
        if (pll_cd > 0) begin pll_cd--; if (pll_cd == 0) pll_ready = 1'b1; end
        if (ch_cd > 0)  begin ch_cd--;  if (ch_cd == 0)  ch_ready  = 1'b1; end
        if (lock_cd > 0) begin lock_cd--; if (lock_cd == 0) pll_locked = 1'b1; end
        if (rst_n) begin
            if (pll_wr || ch_wr) begin
                wr_cnt++;
                if (exp_port.size() == 0) begin
                    chk(0, "R5", "unexpected write addr", pll_wr ? pll_addr : ch_addr, 0);
                end else begin
                    int ep, ea, ed;
                    ep = exp_port.pop_front(); ea = exp_addr.pop_front(); ed = exp_data.pop_front();
                    chk(pll_wr == ep[0], "R5", "write port (1=pll)", pll_wr, ep);
                    if (pll_wr) begin
                        chk(pll_addr == ea && pll_wdata == ed, ea == 'h36 ? "R2" : "R4",
                            "pll addr/data", {pll_addr, pll_wdata}, (ea << 16) | ed);
                    end else begin
                        chk(ch_addr == ea && ch_wdata == ed, ea == 'h88 ? "R3" : "R4",
                            "ch addr/data", {ch_addr, ch_wdata}, (ea << 16) | ed);
                    end
                end
            end
            chk(!pll_rd && !ch_rd, "R5", "read strobe", {pll_rd, ch_rd}, 0);
            chk(up_clk_reset == busy, "R10", "up_clk_reset vs busy", up_clk_reset, busy);
            if (tx_restart || rx_restart) begin
                restart_cnt++;
                chk(tx_restart == rx_restart, "R6", "tx/rx restart pair", tx_restart, rx_restart);
                chk(lock_seen, "R6", "restart before lock", 0, 1);
                chk(busy, "R1", "busy during restart", busy, 1);
            end
            if (done) begin
                done_cnt++;
                chk(!busy, "R1", "busy with done", busy, 0);
            end
            lock_seen = pll_locked;
        end
        if (pll_wr && !pll_drop) pll_cd = pll_lat;
        if (ch_wr && !ch_drop) ch_cd = ch_lat;
        if (pll_reset) begin
            pll_locked = 1'b0;
            lock_seen  = 1'b0;
            if (!lock_never) lock_cd = lock_lat;
        end
    end

    task automatic run(input int code, input int to, input bit ok, input int nwr, input bit mid);
        bit fin;
        int dr_before;
        dr_before = up_double_rate;
        exp_port.delete(); exp_addr.delete(); exp_data.delete();
        push_prog(code, nwr);
        restart_cnt = 0; done_cnt = 0; wr_cnt = 0;
        @(negedge clk); #1;
        start = 1'b1; rate_code = 4'(code); timeout_cycles = 16'(to);
        @(negedge clk); #1;
        start = 1'b0;
        chk(busy == 1'b1, "R1", "busy after start", busy, 1);
        chk(error == 1'b0, "R8", "error cleared by start", error, 0);
        fin = 0;
        for (int i = 0; i < 2000 && !fin; i++) begin
            @(negedge clk); #1;
            if (mid && i == 4) begin start = 1'b1; rate_code = 4'd12; end   // R11
            else start = 1'b0;
            if (done_cnt > 0 || error) fin = 1;
        end
        start = 1'b0;
        chk(fin, "R7", "run finished", fin, 1);
        repeat (3) @(negedge clk);
        #1;
        chk(exp_port.size() == 0 && wr_cnt == nwr, "R5", "write count", wr_cnt, nwr);
        if (ok) begin
            chk(done_cnt == 1 && restart_cnt == 1, "R6", "restart/done count",
                (restart_cnt << 4) | done_cnt, 'h11);
            chk(error == 1'b0, "R7", "error on good run", error, 0);
            chk(up_double_rate == (code >= 10), "R10", "double rate", up_double_rate, code >= 10);
        end else begin
            chk(done_cnt == 0 && restart_cnt == 0, "R7", "no restart/done on failure",
                (restart_cnt << 4) | done_cnt, 0);
            chk(error == 1'b1, "R7", "error set", error, 1);
            if (nwr == 0) begin
                chk(up_double_rate == dr_before, "R9", "double rate kept", up_double_rate, dr_before);
            end
        end
        chk(busy == 1'b0, "R1", "idle after run", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !error && !pll_wr && !ch_wr && !pll_reset && !tx_restart
            && !up_double_rate && !up_clk_reset, "R1", "reset state", busy, 0);
        rst_n = 1'b1;
        // R2 R3 R4 R6 R10: every valid rate
        run(1, 20, 1, 7, 0);
        run(2, 20, 1, 7, 0);
        pll_lat = 1; ch_lat = 1; lock_lat = 1;
        run(3, 20, 1, 7, 0);
        pll_lat = 4; ch_lat = 2; lock_lat = 9;
        run(5, 20, 1, 7, 0);
        run(6, 20, 1, 7, 0);
        run(10, 20, 1, 7, 0);
        run(12, 20, 1, 7, 0);
        // R9: invalid codes, no writes
        run(4, 20, 0, 0, 0);
        run(0, 20, 0, 0, 0);
        run(15, 20, 0, 0, 0);
        // R8: a good run clears the sticky error
        pll_lat = 2; ch_lat = 3; lock_lat = 5;
        run(5, 20, 1, 7, 0);
        // R7: ready exactly at the limit wins, one later loses
        ch_lat = 5; lock_lat = 5;
        run(1, 4, 1, 7, 0);
        ch_lat = 6;
        run(2, 4, 0, 2, 0);
        ch_lat = 3;
        lock_lat = 6;
        run(3, 4, 0, 7, 0);
        lock_lat = 5;
        lock_never = 1;
        run(6, 10, 0, 7, 0);
        lock_never = 0;
        pll_drop = 1;
        run(10, 10, 0, 1, 0);
        pll_drop = 0;
        // R11: start during a run ignored
        run(1, 20, 1, 7, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule